// File: doc/BRIEF.md
# NAND Flash Bus Cycle Timing Generator

This block turns one-beat access requests from an internal master into pin-level NAND flash bus cycles. A request names its kind (command byte, address byte, data read or data write), carries write data, and goes out under the bus width that is currently selected (8 or 16 bits). Each access passes through a setup phase, a wait (strobe) phase and a hold phase. A high-impedance count decides how long the data bus stays undriven at the start of a write. Command and address bytes take their phase lengths from the attribute timing set. Data transfers take theirs from the common timing set.

A data read that directly follows a command or an address byte first passes through a turnaround phase. Its length comes from a separate command-latch-to-read delay or address-latch-to-read delay. When the wait input is enabled, a low level on the device's wait/busy pin stretches the wait phase. Configuration arrives on plain inputs. The timing words and the two delays are captured by a load strobe and fall back to their defaults on reset.

The controller is one state machine with five states. ST_IDLE is the only state that accepts a request. ST_TURN counts the turnaround. ST_SETUP drives the latch enables. ST_WAIT pulses the write or read strobe and holds while the device is busy. ST_HOLD keeps the latch enables after the strobe. The transitions are: ST_IDLE to ST_TURN (accept of a read after a command or address byte); ST_IDLE to ST_SETUP (accept of any other request); ST_TURN to ST_SETUP (turnaround count expired); ST_SETUP to ST_WAIT (setup count expired); ST_WAIT to ST_WAIT (busy stall); ST_WAIT to ST_HOLD (wait count expired, not busy); and ST_HOLD to ST_IDLE (hold count expired).

Top module: `nand_bus_timer`

## Requirements
- R1: After reset, and before any configuration load, every timing field of both sets is 10 cycles (word 0x0A0A0A0A) and both read turnaround delays are 15, which gives 16 cycles.
- R2: A timing word holds four 8-bit fields: setup length in bits 7:0, wait length in bits 15:8, hold length in bits 23:16 and high-impedance count in bits 31:24. The word is captured from the configuration inputs on a cycle with cfg_load high.
- R3: A command (req_kind 0) or address (req_kind 1) access uses the attribute timing set. A data read (req_kind 2) or data write (req_kind 3) uses the common timing set.
- R4: The setup, wait and hold phases each last the field value in cycles, and a field value of 0 gives 1 cycle.
- R5: Chip enable is low for the whole access. The write strobe (writes) or read strobe (reads) is low only during the wait phase. The command latch (command) or address latch (address) is high from the first setup cycle through the last hold cycle.
- R6: For any write kind the data bus output enable stays low for (high-impedance field + 1) cycles from the first cycle of the access, then stays high to the end. A read never drives the bus.
- R7: A read accepted right after a command access keeps chip enable low for (command delay + 1) cycles before its setup phase. A read right after an address access does the same for (address delay + 1) cycles. A read after a data access has no such phase.
- R8: With cfg_wide high, a data write drives all 16 bits and a read returns all 16 bits. With cfg_wide low, or for command and address bytes, only bits 7:0 carry data and bits 15:8 are zero.
- R9: Unless cfg_global_en and cfg_bank_en are both high, req_ready is low, no request is taken and the pins stay idle.
- R10: With cfg_wait_en high, every cycle of the wait phase in which nand_wait_n is low adds one cycle to the wait phase. With cfg_wait_en low, nand_wait_n has no effect.
- R11: req_ready is high in idle, low during an access, and high again in the cycle after the last hold cycle.
- R12: A read returns the value on nand_dq_in in the last wait-phase cycle, on rsp_rdata with rsp_valid high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_global_en | input | 1 | Controller-wide enable |
| cfg_bank_en | input | 1 | NAND bank enable |
| cfg_wait_en | input | 1 | Let nand_wait_n stretch the wait phase |
| cfg_wide | input | 1 | 1 selects the 16-bit data bus, 0 the 8-bit data bus |
| cfg_load | input | 1 | Capture the timing words and delays |
| cfg_common_tim | input | 32 | Timing word for data accesses |
| cfg_attr_tim | input | 32 | Timing word for command and address accesses |
| cfg_cle_re | input | 4 | Command-latch-to-read delay, cycles minus one |
| cfg_ale_re | input | 4 | Address-latch-to-read delay, cycles minus one |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_kind | input | 2 | 0 command, 1 address, 2 data read, 3 data write |
| req_wdata | input | 16 | Command/address byte or write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 16 | Read data |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 16 | Data bus output value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | 16 | Data bus input value |
| nand_wait_n | input | 1 | Device wait/busy, low means busy |

## Verification
The bench builds the block with its defaults: a 16-bit bus and 4-bit turnaround delays. At these values the widest delay (16 cycles) and both byte lanes can be observed. It measures each access in cycles at the pins, counting chip-enable, latch and strobe widths, the first cycle of the strobe and the first cycle of output enable. It then compares those counts with lengths worked out from the timing words. Read data is driven as a value that changes every cycle, so the returned word shows which cycle was sampled. The runs cover the reset defaults, loaded words with distinct fields, all-zero fields and busy stalls with the wait input enabled and disabled.

// File: rtl/nbt_pkg.sv
package nbt_pkg;

    localparam int TIM_FIELD_W = 8;
    localparam int TIM_WORD_W  = 4 * TIM_FIELD_W;
    localparam logic [TIM_WORD_W-1:0] TIM_RESET = 32'h0A0A_0A0A;

    typedef enum logic [1:0] {
        K_CMD  = 2'd0,
        K_ADDR = 2'd1,
        K_RD   = 2'd2,
        K_WR   = 2'd3
    } acc_kind_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_SETUP,
        ST_WAIT,
        ST_HOLD
    } phase_t;

    typedef struct packed {
        logic [TIM_FIELD_W-1:0] hiz;
        logic [TIM_FIELD_W-1:0] hold;
        logic [TIM_FIELD_W-1:0] wt;
        logic [TIM_FIELD_W-1:0] setup;
    } tim_set_t;

    function automatic logic [TIM_FIELD_W-1:0] len_m1(input logic [TIM_FIELD_W-1:0] f);
        return (f == '0) ? '0 : f - 1'b1;
    endfunction

    function automatic logic is_latch_kind(input acc_kind_t k);
        return (k == K_CMD) || (k == K_ADDR);
    endfunction

endpackage

// File: rtl/nbt_phase_cnt.sv
module nbt_phase_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         zero
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

    // R4: phase lengths never wrap below zero
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |-> (cnt != '0));

endmodule

// File: rtl/nbt_cfg_regs.sv
module nbt_cfg_regs
    import nbt_pkg::*;
#(
    parameter int DLY_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_load,
    input  logic [TIM_WORD_W-1:0] common_in,
    input  logic [TIM_WORD_W-1:0] attr_in,
    input  logic [DLY_W-1:0]      cle_in,
    input  logic [DLY_W-1:0]      ale_in,
    input  logic                  sel_attr,
    output tim_set_t              tim_sel,
    output logic [DLY_W-1:0]      cle_dly,
    output logic [DLY_W-1:0]      ale_dly
);

    localparam int NSETS = 2;   // index 0: common space, index 1: attribute space

    logic [TIM_WORD_W-1:0] set_d [NSETS];
    logic [TIM_WORD_W-1:0] set_q [NSETS];

    assign set_d[0] = common_in;
    assign set_d[1] = attr_in;

    for (genvar g = 0; g < NSETS; g++) begin : g_set
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                set_q[g] <= TIM_RESET;
            end else if (cfg_load) begin
                set_q[g] <= set_d[g];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cle_dly <= '1;
            ale_dly <= '1;
        end else if (cfg_load) begin
            cle_dly <= cle_in;
            ale_dly <= ale_in;
        end
    end

    assign tim_sel = tim_set_t'(sel_attr ? set_q[1] : set_q[0]);

endmodule

// File: rtl/nbt_seq.sv
module nbt_seq
    import nbt_pkg::*;
#(
    parameter int BUS_W = 16,
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             wait_en,
    input  logic             wide,
    input  logic             req_valid,
    output logic             req_ready,
    input  acc_kind_t        req_kind,
    input  logic [BUS_W-1:0] req_wdata,
    input  tim_set_t         tim,
    output logic             sel_attr,
    input  logic [DLY_W-1:0] cle_dly,
    input  logic [DLY_W-1:0] ale_dly,
    input  logic             nand_wait_n,
    input  logic [BUS_W-1:0] nand_dq_in,
    output logic             nand_ce_n,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic [BUS_W-1:0] nand_dq_out,
    output logic             nand_dq_oe,
    output logic             rsp_valid,
    output logic [BUS_W-1:0] rsp_rdata
);

    localparam int LANE_W = BUS_W / 2;
    localparam int CNT_W  = TIM_FIELD_W;
    localparam int HIZ_W  = TIM_FIELD_W + 1;

    phase_t          state_q, state_d;
    acc_kind_t       kind_q, last_q;
    logic            wide_q;
    logic [BUS_W-1:0] wdata_q;

    logic             accept;
    logic             stall;
    logic             turn_needed;
    logic [CNT_W-1:0] turn_len;

    logic             ph_load, ph_dec, ph_zero;
    logic [CNT_W-1:0] ph_val, ph_cnt;
    logic             hz_load, hz_dec, hz_zero;
    logic [HIZ_W-1:0] hz_val, hz_cnt;

    assign stall       = wait_en && !nand_wait_n;
    assign turn_needed = (req_kind == K_RD) && is_latch_kind(last_q);
    assign turn_len    = (last_q == K_CMD) ? CNT_W'(cle_dly) : CNT_W'(ale_dly);
    assign sel_attr    = (state_q == ST_IDLE) ? is_latch_kind(req_kind) : is_latch_kind(kind_q);
    assign req_ready   = enable && (state_q == ST_IDLE);

    // next-state and counter control
    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        ph_load = 1'b0;
        ph_dec  = 1'b0;
        ph_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid && enable) begin
                    accept  = 1'b1;
                    ph_load = 1'b1;
                    if (turn_needed) begin
                        state_d = ST_TURN;
                        ph_val  = turn_len;
                    end else begin
                        state_d = ST_SETUP;
                        ph_val  = len_m1(tim.setup);
                    end
                end
            end
            ST_TURN: begin
                if (ph_zero) begin
                    state_d = ST_SETUP;
                    ph_load = 1'b1;
                    ph_val  = len_m1(tim.setup);
                end else begin
                    ph_dec = 1'b1;
                end
            end
            ST_SETUP: begin
                if (ph_zero) begin
                    state_d = ST_WAIT;
                    ph_load = 1'b1;
                    ph_val  = len_m1(tim.wt);
                end else begin
                    ph_dec = 1'b1;
                end
            end
            ST_WAIT: begin
                if (!stall) begin
                    if (ph_zero) begin
                        state_d = ST_HOLD;
                        ph_load = 1'b1;
                        ph_val  = len_m1(tim.hold);
                    end else begin
                        ph_dec = 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (ph_zero) begin
                    state_d = ST_IDLE;
                end else begin
                    ph_dec = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign hz_load = accept;
    assign hz_val  = HIZ_W'(tim.hiz) + 1'b1;
    assign hz_dec  = (state_q != ST_IDLE) && !hz_zero;

    nbt_phase_cnt #(.W(CNT_W)) u_phase_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .dec      (ph_dec),
        .cnt      (ph_cnt),
        .zero     (ph_zero)
    );

    nbt_phase_cnt #(.W(HIZ_W)) u_hiz_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (hz_load),
        .load_val (hz_val),
        .dec      (hz_dec),
        .cnt      (hz_cnt),
        .zero     (hz_zero)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // request capture and read return
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q    <= K_RD;
            last_q    <= K_RD;
            wide_q    <= 1'b0;
            wdata_q   <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            if (accept) begin
                kind_q  <= req_kind;
                last_q  <= req_kind;
                wide_q  <= wide;
                wdata_q <= req_wdata;
            end
            rsp_valid <= 1'b0;
            if ((state_q == ST_WAIT) && ph_zero && !stall && (kind_q == K_RD)) begin
                rsp_valid <= 1'b1;
                rsp_rdata <= wide_q ? nand_dq_in : {{(BUS_W-LANE_W){1'b0}}, nand_dq_in[LANE_W-1:0]};
            end
        end
    end

    // pin outputs
    always_comb begin
        logic active;
        logic latch_ph;
        active      = (state_q != ST_IDLE);
        latch_ph    = (state_q == ST_SETUP) || (state_q == ST_WAIT) || (state_q == ST_HOLD);
        nand_ce_n   = !active;
        nand_cle    = latch_ph && (kind_q == K_CMD);
        nand_ale    = latch_ph && (kind_q == K_ADDR);
        nand_we_n   = !((state_q == ST_WAIT) && (kind_q != K_RD));
        nand_re_n   = !((state_q == ST_WAIT) && (kind_q == K_RD));
        nand_dq_oe  = active && (kind_q != K_RD) && hz_zero;
        if ((kind_q == K_WR) && wide_q) begin
            nand_dq_out = wdata_q;
        end else begin
            nand_dq_out = {{(BUS_W-LANE_W){1'b0}}, wdata_q[LANE_W-1:0]};
        end
    end

    // R5: strobes exclusive, only inside chip-enable
    assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));
    assert_strobe_in_ce_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n);
    assert_latch_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));
    // R6: a read never drives the bus
    assert_read_no_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> !nand_dq_oe);
    // R8: upper lane quiet unless a wide data write
    assert_upper_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (nand_cle || nand_ale) |-> (nand_dq_out[BUS_W-1:LANE_W] == '0));
    // R10: busy keeps the wait phase
    assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_WAIT) && stall) |=> (state_q == ST_WAIT));

endmodule

// File: rtl/nand_bus_timer.sv
module nand_bus_timer
    import nbt_pkg::*;
#(
    parameter int BUS_W = 16,
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_global_en,
    input  logic             cfg_bank_en,
    input  logic             cfg_wait_en,
    input  logic             cfg_wide,
    input  logic             cfg_load,
    input  logic [31:0]      cfg_common_tim,
    input  logic [31:0]      cfg_attr_tim,
    input  logic [DLY_W-1:0] cfg_cle_re,
    input  logic [DLY_W-1:0] cfg_ale_re,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_kind,
    input  logic [BUS_W-1:0] req_wdata,
    output logic             rsp_valid,
    output logic [BUS_W-1:0] rsp_rdata,
    output logic             nand_ce_n,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic [BUS_W-1:0] nand_dq_out,
    output logic             nand_dq_oe,
    input  logic [BUS_W-1:0] nand_dq_in,
    input  logic             nand_wait_n
);

    tim_set_t         tim_sel;
    logic             sel_attr;
    logic [DLY_W-1:0] cle_dly, ale_dly;
    logic             enable;

    assign enable = cfg_global_en && cfg_bank_en;

    nbt_cfg_regs #(.DLY_W(DLY_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_load  (cfg_load),
        .common_in (cfg_common_tim),
        .attr_in   (cfg_attr_tim),
        .cle_in    (cfg_cle_re),
        .ale_in    (cfg_ale_re),
        .sel_attr  (sel_attr),
        .tim_sel   (tim_sel),
        .cle_dly   (cle_dly),
        .ale_dly   (ale_dly)
    );

    nbt_seq #(.BUS_W(BUS_W), .DLY_W(DLY_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .wait_en     (cfg_wait_en),
        .wide        (cfg_wide),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_kind    (acc_kind_t'(req_kind)),
        .req_wdata   (req_wdata),
        .tim         (tim_sel),
        .sel_attr    (sel_attr),
        .cle_dly     (cle_dly),
        .ale_dly     (ale_dly),
        .nand_wait_n (nand_wait_n),
        .nand_dq_in  (nand_dq_in),
        .nand_ce_n   (nand_ce_n),
        .nand_cle    (nand_cle),
        .nand_ale    (nand_ale),
        .nand_we_n   (nand_we_n),
        .nand_re_n   (nand_re_n),
        .nand_dq_out (nand_dq_out),
        .nand_dq_oe  (nand_dq_oe),
        .rsp_valid   (rsp_valid),
        .rsp_rdata   (rsp_rdata)
    );

    // R9: no acceptance while disabled
    assert_disabled_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_global_en && cfg_bank_en) |-> !req_ready);
    // R11: ready only while the bus is idle
    assert_ready_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> nand_ce_n);
    // R12: response lasts a single cycle
    assert_rsp_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

// File: tb/nand_bus_timer_bench.sv
module nand_bus_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_global_en = 1'b0, cfg_bank_en = 1'b0, cfg_wait_en = 1'b0, cfg_wide = 1'b0;
    logic        cfg_load = 1'b0;
    logic [31:0] cfg_common_tim = '0, cfg_attr_tim = '0;
    logic [3:0]  cfg_cle_re = '0, cfg_ale_re = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = 2'd0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [15:0] nand_dq_out;
    logic [15:0] nand_dq_in = '0;
    logic        nand_wait_n = 1'b1;

    int n_vec = 0;
    int n_bad = 0;

    // measurements of the last access
    int m_ce, m_cle, m_ale, m_we, m_re, m_strobe_first, m_oe_first, m_rsp;
    int m_rdata, m_dq;
    int m_ready_during, m_ready_after;

    always #4 clk = ~clk;

    nand_bus_timer u_nand_bus_timer (
        .clk(clk), .rst_n(rst_n),
        .cfg_global_en(cfg_global_en), .cfg_bank_en(cfg_bank_en),
        .cfg_wait_en(cfg_wait_en), .cfg_wide(cfg_wide), .cfg_load(cfg_load),
        .cfg_common_tim(cfg_common_tim), .cfg_attr_tim(cfg_attr_tim),
        .cfg_cle_re(cfg_cle_re), .cfg_ale_re(cfg_ale_re),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
        .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_wait_n(nand_wait_n)
    );

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        summary();
        $finish;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic load_cfg(input logic [31:0] com, input logic [31:0] att,
                            input logic [3:0] cle, input logic [3:0] ale);
        @(negedge clk);
        cfg_common_tim = com;
        cfg_attr_tim   = att;
        cfg_cle_re     = cle;
        cfg_ale_re     = ale;
        cfg_load       = 1'b1;
        @(negedge clk);
        cfg_load       = 1'b0;
    endtask

    // issue one access and measure it cycle by cycle at the pins
    task automatic run_access(input logic [1:0] kind, input logic [15:0] wd,
                              input int busy_start, input int busy_len);
        int idx;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_kind  = kind;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        m_ce = 0; m_cle = 0; m_ale = 0; m_we = 0; m_re = 0; m_rsp = 0;
        m_strobe_first = -1; m_oe_first = -1; m_rdata = -1; m_dq = -1;
        m_ready_during = req_ready;
        idx = 0;
        while (!nand_ce_n && idx < 2000) begin
            nand_dq_in  = 16'hA000 + 16'(idx);
            nand_wait_n = !(idx >= busy_start && idx < busy_start + busy_len);
            m_ce++;
            if (nand_cle) m_cle++;
            if (nand_ale) m_ale++;
            if (!nand_we_n) m_we++;
            if (!nand_re_n) m_re++;
            if ((!nand_we_n || !nand_re_n) && m_strobe_first < 0) m_strobe_first = idx;
            if (nand_dq_oe && m_oe_first < 0) begin
                m_oe_first = idx;
                m_dq = nand_dq_out;
            end
            if (rsp_valid) begin
                m_rsp++;
                m_rdata = rsp_rdata;
            end
            idx++;
            @(negedge clk);
        end
        nand_wait_n = 1'b1;
        if (rsp_valid) m_rsp++;
        m_ready_after = req_ready;
    endtask

    task automatic t_reset_state();
        chk("R9 ready low while disabled", req_ready, 0);
        chk("R5 ce_n idle", nand_ce_n, 1);
        chk("R5 we_n idle", nand_we_n, 1);
        chk("R5 re_n idle", nand_re_n, 1);
        chk("R5 cle/ale idle", {nand_cle, nand_ale}, 0);
        chk("R6 dq_oe idle", nand_dq_oe, 0);
        chk("R12 rsp_valid idle", rsp_valid, 0);
    endtask

    task automatic t_enable_gate();
        cfg_global_en = 1'b1;
        cfg_bank_en   = 1'b0;
        @(negedge clk);
        req_valid = 1'b1;
        req_kind  = 2'd0;
        req_wdata = 16'h0070;
        repeat (20) begin
            @(negedge clk);
            chk("R9 no ready, bank off", req_ready, 0);
            chk("R9 no ce, bank off", nand_ce_n, 1);
        end
        req_valid = 1'b0;
        cfg_global_en = 1'b0;
        cfg_bank_en   = 1'b1;
        @(negedge clk);
        chk("R9 no ready, global off", req_ready, 0);
        cfg_global_en = 1'b1;
        @(negedge clk);
        chk("R11 ready when enabled and idle", req_ready, 1);
    endtask

    task automatic t_default_cmd();
        run_access(2'd0, 16'h00FF, 999, 0);
        chk("R1 default cmd ce width", m_ce, 30);
        chk("R5 R1 cle width", m_cle, 30);
        chk("R5 no ale on cmd", m_ale, 0);
        chk("R1 we width", m_we, 10);
        chk("R1 we start", m_strobe_first, 10);
        chk("R6 R1 hiz start", m_oe_first, 11);
        chk("R8 cmd byte on bus", m_dq, 16'h00FF);
        chk("R11 ready low during", m_ready_during, 0);
        chk("R11 ready after hold", m_ready_after, 1);
    endtask

    task automatic t_default_read_after_cmd();
        cfg_wide = 1'b0;
        run_access(2'd2, 16'h0, 999, 0);
        chk("R7 R1 turnaround ce width", m_ce, 46);
        chk("R7 R1 re start", m_strobe_first, 26);
        chk("R5 re width", m_re, 10);
        chk("R5 no we on read", m_we, 0);
        chk("R6 read never drives", m_oe_first, -1);
        chk("R12 one rsp pulse", m_rsp, 1);
        chk("R12 R8 narrow read data", m_rdata, 16'h0023);
    endtask

    task automatic t_loaded_cmd_addr();
        load_cfg(32'h0203_0402, 32'h0102_0301, 4'd2, 4'd5);
        cfg_wide = 1'b1;
        run_access(2'd0, 16'hBE5A, 999, 0);
        chk("R3 R2 attr cmd ce width", m_ce, 6);
        chk("R2 cmd we start", m_strobe_first, 1);
        chk("R2 cmd we width", m_we, 3);
        chk("R6 cmd hiz start", m_oe_first, 2);
        chk("R8 cmd low byte only when wide", m_dq, 16'h005A);
        run_access(2'd1, 16'h1234, 999, 0);
        chk("R3 addr ce width", m_ce, 6);
        chk("R5 ale width", m_ale, 6);
        chk("R5 no cle on addr", m_cle, 0);
        chk("R8 addr low byte", m_dq, 16'h0034);
    endtask

    task automatic t_read_after_addr();
        run_access(2'd2, 16'h0, 999, 0);
        chk("R7 ale turnaround ce width", m_ce, 15);
        chk("R7 R3 re start", m_strobe_first, 8);
        chk("R3 common wait", m_re, 4);
        chk("R12 R8 wide read data", m_rdata, 16'hA00B);
    endtask

    task automatic t_data_writes();
        run_access(2'd3, 16'hC3A5, 999, 0);
        chk("R7 no turnaround, write ce", m_ce, 9);
        chk("R3 write we start", m_strobe_first, 2);
        chk("R3 write we width", m_we, 4);
        chk("R6 write hiz start", m_oe_first, 3);
        chk("R8 wide write data", m_dq, 16'hC3A5);
        cfg_wide = 1'b0;
        run_access(2'd3, 16'hC3A5, 999, 0);
        chk("R8 narrow write data", m_dq, 16'h00A5);
    endtask

    task automatic t_zero_fields();
        load_cfg(32'h0000_0000, 32'h0102_0301, 4'd2, 4'd5);
        run_access(2'd3, 16'h0011, 999, 0);
        chk("R4 zero write ce", m_ce, 3);
        chk("R4 zero we start", m_strobe_first, 1);
        chk("R4 zero we width", m_we, 1);
        chk("R6 zero hiz start", m_oe_first, 1);
        run_access(2'd2, 16'h0, 999, 0);
        chk("R7 R4 read after data ce", m_ce, 3);
        chk("R12 zero read sample", m_rdata, 16'h0001);
    endtask

    task automatic t_wait_stretch();
        load_cfg(32'h0203_0402, 32'h0102_0301, 4'd2, 4'd5);
        cfg_wait_en = 1'b1;
        run_access(2'd3, 16'h0022, 2, 3);
        chk("R10 stretched we width", m_we, 7);
        chk("R10 stretched ce", m_ce, 12);
        cfg_wide = 1'b1;
        run_access(2'd2, 16'h0, 2, 3);
        chk("R10 stretched re width", m_re, 7);
        chk("R12 R10 sample after stall", m_rdata, 16'hA008);
        cfg_wait_en = 1'b0;
        run_access(2'd3, 16'h0022, 2, 3);
        chk("R10 busy ignored we width", m_we, 4);
        chk("R10 busy ignored ce", m_ce, 9);
    endtask

    initial begin : main
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_enable_gate();
        t_default_cmd();
        t_default_read_after_cmd();
        t_loaded_cmd_addr();
        t_read_after_addr();
        t_data_writes();
        t_zero_fields();
        t_wait_stretch();
        repeat (4) @(negedge clk);
        summary();
        $finish;
    end

endmodule